// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time as seven fields (second, minute, hour, weekday, day of month, month and a two-digit year) and steps them forward by one second each time a one-cycle strobe arrives. Carries ripple from seconds up to the year. Month lengths are real, and February follows the full Gregorian leap-year rule. The rule uses a binary century value supplied on an input together with the stored two-digit year.

Values are stored internally in binary. Each field is presented on its own output byte, as packed BCD or plain binary. The hour is shown either as 0–23 or as a 12-hour value with a PM flag. Both choices follow two mode inputs and take effect at once. Host writes are decoded with the same modes. They are collected while a hold input is high and are copied into the running count only when hold is released. A half-finished time entry therefore never takes part in a carry.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the time is 00:00:00, weekday 1, day 1, month 1, year 0.
- R2: A `tick_i` pulse with `hold_i` low advances the time by exactly one second. Seconds and minutes go from 59 to 0 and hours go from 23 to 0, and each of these wraps carries one into the next field.
- R3: Weekday runs 1 to 7. On every carry into the day it advances, and 7 becomes 1.
- R4: Month lengths are 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and 28 or 29 for month 2. A day carry past the length sets the day to 1 and advances the month.
- R5: February has 29 days when the four-digit year (`century_i`*100 + year) is divisible by 4, unless it is divisible by 100 but not by 400.
- R6: A month carry past 12 sets the month to 1 and advances the year, and year 99 becomes 0.
- R7: With `fmt_bin_i`=1 every output field is plain binary. With `fmt_bin_i`=0 it is packed BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0.
- R8: With `fmt_24h_i`=1 the hour field shows 0–23. With `fmt_24h_i`=0 it shows hour modulo 12 in bits 6:0, with bit 7 set for hours 12–23. Hour 12 is therefore shown as 0 with bit 7 set.
- R9: Written data is decoded with the current modes. `wr_sel_i` selects the field: 0 second, 1 minute, 2 hour, 3 weekday, 4 day, 5 month, 6 year, and 7 selects nothing. In 12-hour mode a written hour with bit 7 set has 12 added.
- R10: Writes are accepted only while `hold_i` is high. The outputs keep the old time, and ticks have no effect, until the cycle after `hold_i` falls. In that cycle the collected fields replace the count. A write with `hold_i` low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-second advance strobe, one cycle wide |
| hold_i | input | 1 | Freeze the count and accept field writes |
| fmt_bin_i | input | 1 | 1 selects binary, 0 selects packed BCD |
| fmt_24h_i | input | 1 | 1 selects 24-hour, 0 selects 12-hour with PM flag |
| century_i | input | CENT_W | Binary century used by the leap-year rule |
| wr_en_i | input | 1 | Field write strobe |
| wr_sel_i | input | 3 | Field selector for a write |
| wr_data_i | input | 8 | Encoded field value for a write |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hour, with PM flag in 12-hour mode |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Two-digit year |

## Verification
The range properties assume that the host only writes legal values: a second or minute below 60, an hour that decodes below 24, a weekday from 1 to 7, a month from 1 to 12, and a day inside that month. The range properties also assume that BCD data written in BCD mode holds valid digits. The stimulus loads every time through a task that encodes legal binary values with the active modes. The only raw write is the 12-hour PM case, and it uses a legal hour. The step properties assume that a tick is a single-cycle pulse. The bench drives each tick for exactly one clock.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  localparam int SEC_W  = 6;
  localparam int HOUR_W = 5;
  localparam int WDAY_W = 3;
  localparam int MDAY_W = 5;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 7;
  localparam int BYTE_W = 8;
  localparam int VAL_W  = BYTE_W - 1;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  mon;
    logic [MDAY_W-1:0] mday;
    logic [WDAY_W-1:0] wday;
    logic [HOUR_W-1:0] hour;
    logic [SEC_W-1:0]  min;
    logic [SEC_W-1:0]  sec;
  } rtc_time_t;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_MDAY = 3'd4,
    FLD_MON  = 3'd5,
    FLD_YEAR = 3'd6,
    FLD_NONE = 3'd7
  } rtc_field_e;

  localparam rtc_time_t TIME_AT_RESET = '{
    year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
    hour: 5'd0, min: 6'd0, sec: 6'd0
  };

  // binary 0..99 to two packed decimal digits
  function automatic logic [BYTE_W-1:0] bin2bcd(input logic [VAL_W-1:0] v);
    logic [VAL_W-1:0] tens, units;
    tens  = v / 7'd10;
    units = v - tens * 7'd10;
    return {tens[3:0], units[3:0]};
  endfunction

  // two packed decimal digits to binary
  function automatic logic [VAL_W-1:0] bcd2bin(input logic [BYTE_W-1:0] b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
  import rtc_cal_pkg::*;
#(
  parameter int CENT_W = 8
) (
  input  rtc_time_t         cur_i,
  input  logic [CENT_W-1:0] century_i,
  output rtc_time_t         nxt_o
);

  logic              leap;
  logic [MDAY_W-1:0] month_len;
  logic              day_carry;

  // full year = century*100 + yy; 100 is a multiple of 4, so only yy==0 needs the century
  assign leap = (cur_i.year[1:0] == 2'd0) &&
                ((cur_i.year != '0) || (century_i[1:0] == 2'd0));

  always_comb begin
    case (cur_i.mon)
      4'd2:                      month_len = leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   month_len = 5'd30;
      default:                   month_len = 5'd31;
    endcase
  end

  always_comb begin
    nxt_o     = cur_i;
    day_carry = 1'b0;
    if (cur_i.sec >= 6'd59) begin
      nxt_o.sec = '0;
      if (cur_i.min >= 6'd59) begin
        nxt_o.min = '0;
        if (cur_i.hour >= 5'd23) begin
          nxt_o.hour = '0;
          day_carry  = 1'b1;
        end else begin
          nxt_o.hour = cur_i.hour + 1'b1;
        end
      end else begin
        nxt_o.min = cur_i.min + 1'b1;
      end
    end else begin
      nxt_o.sec = cur_i.sec + 1'b1;
    end

    if (day_carry) begin
      nxt_o.wday = (cur_i.wday >= 3'd7) ? 3'd1 : cur_i.wday + 1'b1;
      if (cur_i.mday >= month_len) begin
        nxt_o.mday = 5'd1;
        if (cur_i.mon >= 4'd12) begin
          nxt_o.mon  = 4'd1;
          nxt_o.year = (cur_i.year >= 7'd99) ? 7'd0 : cur_i.year + 1'b1;
        end else begin
          nxt_o.mon = cur_i.mon + 1'b1;
        end
      end else begin
        nxt_o.mday = cur_i.mday + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rtc_cal_load.sv
module rtc_cal_load
  import rtc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hold_i,
  input  logic              fmt_bin_i,
  input  logic              fmt_24h_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  rtc_time_t         cur_i,
  output rtc_time_t         shadow_o
);

  rtc_time_t        shd_q, shd_d;
  logic [VAL_W-1:0] val, hr_raw, hr_val;
  rtc_field_e       sel;

  assign sel    = rtc_field_e'(wr_sel_i);
  assign val    = fmt_bin_i ? wr_data_i[VAL_W-1:0] : bcd2bin(wr_data_i);
  assign hr_raw = fmt_bin_i ? wr_data_i[VAL_W-1:0] : bcd2bin({1'b0, wr_data_i[VAL_W-1:0]});
  assign hr_val = (!fmt_24h_i && wr_data_i[BYTE_W-1]) ? hr_raw + 7'd12 : hr_raw;

  always_comb begin
    shd_d = shd_q;
    if (!hold_i) begin
      shd_d = cur_i;
    end else if (wr_en_i) begin
      case (sel)
        FLD_SEC:  shd_d.sec  = val[SEC_W-1:0];
        FLD_MIN:  shd_d.min  = val[SEC_W-1:0];
        FLD_HOUR: shd_d.hour = hr_val[HOUR_W-1:0];
        FLD_WDAY: shd_d.wday = val[WDAY_W-1:0];
        FLD_MDAY: shd_d.mday = val[MDAY_W-1:0];
        FLD_MON:  shd_d.mon  = val[MON_W-1:0];
        FLD_YEAR: shd_d.year = val[YEAR_W-1:0];
        default:  shd_d = shd_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shd_q <= TIME_AT_RESET;
    else         shd_q <= shd_d;
  end

  assign shadow_o = shd_q;

  // R10: while held, the collected time only changes through a write
  a_r10_shadow_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !wr_en_i) |=> (shd_q == $past(shd_q)));

endmodule

// File: rtl/rtc_cal_view.sv
module rtc_cal_view
  import rtc_cal_pkg::*;
(
  input  rtc_time_t         cur_i,
  input  logic              fmt_bin_i,
  input  logic              fmt_24h_i,
  output logic [BYTE_W-1:0] sec_o,
  output logic [BYTE_W-1:0] min_o,
  output logic [BYTE_W-1:0] hour_o,
  output logic [BYTE_W-1:0] wday_o,
  output logic [BYTE_W-1:0] mday_o,
  output logic [BYTE_W-1:0] month_o,
  output logic [BYTE_W-1:0] year_o
);

  localparam int NPLAIN = 6;

  logic [VAL_W-1:0]  plain [NPLAIN];
  logic [BYTE_W-1:0] coded [NPLAIN];
  logic              pm;
  logic [VAL_W-1:0]  hr_disp;

  assign plain[0] = VAL_W'(cur_i.sec);
  assign plain[1] = VAL_W'(cur_i.min);
  assign plain[2] = VAL_W'(cur_i.wday);
  assign plain[3] = VAL_W'(cur_i.mday);
  assign plain[4] = VAL_W'(cur_i.mon);
  assign plain[5] = VAL_W'(cur_i.year);

  for (genvar g = 0; g < NPLAIN; g++) begin : g_enc
    assign coded[g] = fmt_bin_i ? {1'b0, plain[g]} : bin2bcd(plain[g]);
  end

  assign sec_o   = coded[0];
  assign min_o   = coded[1];
  assign wday_o  = coded[2];
  assign mday_o  = coded[3];
  assign month_o = coded[4];
  assign year_o  = coded[5];

  assign pm      = !fmt_24h_i && (cur_i.hour >= 5'd12);
  assign hr_disp = pm ? VAL_W'(cur_i.hour) - 7'd12 : VAL_W'(cur_i.hour);
  assign hour_o  = {pm, 7'd0} | (fmt_bin_i ? {1'b0, hr_disp} : bin2bcd(hr_disp));

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
  import rtc_cal_pkg::*;
#(
  parameter int CENT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              hold_i,
  input  logic              fmt_bin_i,
  input  logic              fmt_24h_i,
  input  logic [CENT_W-1:0] century_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_sel_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        wday_o,
  output logic [7:0]        mday_o,
  output logic [7:0]        month_o,
  output logic [7:0]        year_o
);

  rtc_time_t cur_q, cur_d, stepped, shadow;
  logic      hold_q;
  logic      release_evt, advance, cur_en;

  rtc_cal_step #(.CENT_W(CENT_W)) i_step (
    .cur_i     (cur_q),
    .century_i (century_i),
    .nxt_o     (stepped)
  );

  rtc_cal_load i_load (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold_i),
    .fmt_bin_i (fmt_bin_i),
    .fmt_24h_i (fmt_24h_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .cur_i     (cur_q),
    .shadow_o  (shadow)
  );

  rtc_cal_view i_view (
    .cur_i     (cur_q),
    .fmt_bin_i (fmt_bin_i),
    .fmt_24h_i (fmt_24h_i),
    .sec_o     (sec_o),
    .min_o     (min_o),
    .hour_o    (hour_o),
    .wday_o    (wday_o),
    .mday_o    (mday_o),
    .month_o   (month_o),
    .year_o    (year_o)
  );

  assign release_evt = hold_q && !hold_i;
  assign advance     = tick_i && !hold_i;
  assign cur_en      = release_evt || advance;
  assign cur_d       = release_evt ? shadow : stepped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b0;
    else         hold_q <= hold_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_q <= TIME_AT_RESET;
    else if (cur_en) cur_q <= cur_d;
  end

  // R2: a plain tick moves the seconds up by one when no wrap is due
  a_r2_sec_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !hold_i && !hold_q && cur_q.sec < 6'd59)
      |=> (cur_q.sec == $past(cur_q.sec) + 6'd1));

  // R2: time-of-day fields stay inside their ranges
  a_r2_tod_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.sec < 6'd60) && (cur_q.min < 6'd60) && (cur_q.hour < 5'd24));

  // R3: weekday stays 1..7
  a_r3_wday_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.wday != 3'd0));

  // R4: day and month stay legal
  a_r4_date_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.mday != 5'd0) && (cur_q.mon != 4'd0) && (cur_q.mon <= 4'd12));

  // R6: year never leaves 0..99
  a_r6_year_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q.year <= 7'd99));

  // R10: the running count is frozen while hold is high
  a_r10_hold_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> $stable(cur_q));

  // R10: releasing hold installs the collected fields
  a_r10_release_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !hold_i) |=> (cur_q == $past(shadow)));

endmodule

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, hold = 1'b0, bin = 1'b0, h24 = 1'b1;
  logic [7:0] cent = 8'd20;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o;

  always #5 clk = ~clk;

  rtc_calendar_core i_rtc_calendar_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .hold_i(hold),
    .fmt_bin_i(bin), .fmt_24h_i(h24), .century_i(cent),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .month_o(month_o), .year_o(year_o)
  );

  typedef struct { string tag; logic [55:0] exp; } sb_item_t;
  sb_item_t sbq[$];
  int  n_vec = 0, n_bad = 0;
  logic chk_req = 1'b0;
  bit  done = 1'b0;

  // reference time in binary
  int m_sec, m_min, m_hour, m_wday, m_mday, m_mon, m_year;

  function automatic logic [7:0] enc(int v);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc_hr(int h);
    if (h24) return enc(h);
    return enc(h % 12) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic logic [55:0] model_word();
    return {enc(m_year), enc(m_mon), enc(m_mday), enc(m_wday),
            enc_hr(m_hour), enc(m_min), enc(m_sec)};
  endfunction

  function automatic int days_in(int mon, int yy);
    int full;
    full = cent * 100 + yy;
    if (mon == 2)
      return ((full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0))) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  task automatic model_tick();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin m_min = 0; m_hour++; end
    if (m_hour == 24) begin
      m_hour = 0;
      m_wday = (m_wday == 7) ? 1 : m_wday + 1;
      m_mday++;
      if (m_mday > days_in(m_mon, m_year)) begin
        m_mday = 1; m_mon++;
        if (m_mon == 13) begin m_mon = 1; m_year = (m_year + 1) % 100; end
      end
    end
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial begin
    sb_item_t it;
    logic [55:0] got;
    forever begin
      @(posedge clk);
      #2;
      if (chk_req) begin
        got = {year_o, month_o, mday_o, wday_o, hour_o, min_o, sec_o};
        n_vec++;
        if (sbq.size() == 0) begin
          n_bad++;
          $display("FAIL scoreboard empty: got %h expected an item", got);
        end else begin
          it = sbq.pop_front();
          if (got !== it.exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
          end
        end
      end
    end
  end

  // driver side: queue the reference and request one compare (call at a negedge)
  task automatic expect_now(string tag);
    sbq.push_back('{tag, model_word()});
    chk_req = 1'b1;
    @(negedge clk);
    chk_req = 1'b0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_tick();
  endtask

  task automatic put_field(int sel, logic [7:0] data);
    wr_en = 1'b1; wr_sel = 3'(sel); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all(int s, int mi, int h, int wd, int md, int mo, int y);
    hold = 1'b1;
    put_field(0, enc(s));
    put_field(1, enc(mi));
    put_field(2, enc_hr(h));
    put_field(3, enc(wd));
    put_field(4, enc(md));
    put_field(5, enc(mo));
    put_field(6, enc(y));
    hold = 1'b0;
    @(negedge clk);
    m_sec = s; m_min = mi; m_hour = h; m_wday = wd; m_mday = md; m_mon = mo; m_year = y;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_sec = 0; m_min = 0; m_hour = 0; m_wday = 1; m_mday = 1; m_mon = 1; m_year = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_now("R1 reset time");

    // R2: plain second step, minute carry, hour carry
    load_all(30, 20, 10, 3, 15, 6, 45);
    do_tick(); expect_now("R2 second step");
    load_all(59, 58, 12, 3, 15, 6, 45);
    do_tick(); expect_now("R2 minute carry");
    load_all(59, 59, 13, 3, 15, 6, 45);
    do_tick(); expect_now("R2 hour carry");

    // R6 and R3: full rollover at year 99
    cent = 8'd19;
    load_all(59, 59, 23, 7, 31, 12, 99);
    do_tick(); expect_now("R6 R3 year and weekday wrap");

    // R4: 30- and 31-day months
    cent = 8'd20;
    load_all(59, 59, 23, 2, 30, 4, 21);
    do_tick(); expect_now("R4 april end");
    load_all(59, 59, 23, 2, 30, 1, 21);
    do_tick(); expect_now("R4 january day 30 to 31");
    load_all(59, 59, 23, 3, 31, 1, 21);
    do_tick(); expect_now("R4 january end");

    // R5: leap rules
    load_all(59, 59, 23, 4, 28, 2, 24);
    do_tick(); expect_now("R5 2024 feb 29");
    load_all(59, 59, 23, 4, 29, 2, 24);
    do_tick(); expect_now("R5 2024 leap day end");
    load_all(59, 59, 23, 4, 28, 2, 0);
    do_tick(); expect_now("R5 2000 leap");
    cent = 8'd19;
    load_all(59, 59, 23, 4, 28, 2, 0);
    do_tick(); expect_now("R5 1900 not leap");
    cent = 8'd20;
    load_all(59, 59, 23, 4, 28, 2, 23);
    do_tick(); expect_now("R5 2023 not leap");

    // R7: binary presentation, loaded and counted in binary
    bin = 1'b1;
    @(negedge clk);
    expect_now("R7 binary view");
    load_all(59, 59, 22, 5, 9, 11, 87);
    do_tick(); expect_now("R7 binary count");

    // R8: 12-hour presentation
    h24 = 1'b0;
    @(negedge clk);
    expect_now("R8 12h binary 23h");
    bin = 1'b0;
    load_all(0, 5, 13, 5, 9, 11, 87);
    expect_now("R8 12h 13h");
    load_all(0, 5, 0, 5, 9, 11, 87);
    expect_now("R8 12h midnight");
    load_all(0, 5, 12, 5, 9, 11, 87);
    expect_now("R8 12h noon");

    // R9: raw 12-hour write with PM flag adds 12
    hold = 1'b1;
    put_field(2, 8'h83);
    hold = 1'b0;
    @(negedge clk);
    m_hour = 15;
    h24 = 1'b1;
    @(negedge clk);
    expect_now("R9 pm write to 24h view");
    hold = 1'b1;
    put_field(7, 8'h11);
    hold = 1'b0;
    @(negedge clk);
    expect_now("R9 selector 7 writes nothing");

    // R10: write with hold low is ignored
    put_field(0, enc(33));
    @(negedge clk);
    expect_now("R10 write without hold");
    // R10: tick during hold ignored, write invisible until release
    hold = 1'b1;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    expect_now("R10 tick during hold");
    put_field(0, enc(7));
    expect_now("R10 write pending");
    hold = 1'b0;
    @(negedge clk);
    m_sec = 7;
    expect_now("R10 write applied on release");
    do_tick(); expect_now("R10 count resumes");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule